// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a page table entry held in a hashed table in memory. A request carries the segment register value, the effective address and a store flag. The walker derives a hash from the segment's virtual ID and the page index. It probes every slot of the primary group, then every slot of the secondary group. The secondary group is addressed with the complemented hash. All memory traffic goes through a request/acknowledge read port that returns one 32-bit word per request.

For each slot the walker reads the entry's first word. It reads the second word only once the first word has matched, so the validity-bearing word is always fetched first. On a hit it sets the referenced bit, and the changed bit when the access is a store, with single-byte writes back into the entry. A load that finds the changed bit clear is reported with write permission withheld. A later store then comes back through the walker to mark the page dirty. Results stay on the outputs until the next request is accepted. The protection decision and the fault encoding are left to the consumer.

Top module: `hptw_top`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: busy, done, rd_req and wr_en are all 0.
- R2: The first read of a walk targets tbl_base + (((vsid XOR pidx) << 6) AND tbl_mask). Here vsid = req_sr[23:0], pidx = req_ea[27:12], and the XOR is taken on 32 bits with zero extension.
- R3: A first word w matches when w[31] = 1 (valid), w[6] equals the pass (0 primary, 1 secondary), and w with bits 31 and 6 cleared equals the tag {1'b0, vsid, 1'b0, pidx[15:10]}.
- R4: Slots are probed in ascending order at group offset + 8 × slot. Each probe reads the first word at the entry address. The second word at entry address + 4 is read only after that first word matched, and then the search stops.
- R5: If none of the 8 primary slots match, the walk continues with the secondary group. Its offset is ((NOT hash) << 6) AND tbl_mask, and it starts at slot 0.
- R6: When both groups miss, done pulses for one cycle with hit = 0 and no_write = 0, and no byte is written.
- R7: On a hit whose second word has bit 8 (referenced) clear, the byte at entry address + 6 is written with word1[15:8] OR 0x01.
- R8: On a store hit whose second word has bit 7 (changed) clear, the byte at entry address + 7 is written with word1[7:0] OR 0x80. This write follows any referenced-byte write.
- R9: On a non-store hit with bit 7 clear, no_write is 1 and no changed-byte write is made. In every other case no_write is 0.
- R10: At done after a hit, pte0 and pte1 are the two words as read, pte_addr is the entry address, and real_addr is {pte1[31:12], req_ea[11:0]}.
- R11: A request presented while busy is ignored, and the walk in progress completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_sr | input | 32 | Segment register value; bits 23:0 are the virtual segment ID |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Table base address (64-byte aligned) |
| tbl_mask | input | 32 | Table offset mask |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Word address of the read |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 32 | Byte address of the write |
| wr_byte | output | 8 | Byte to write |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A matching entry was found |
| no_write | output | 1 | Write permission must be withheld |
| pte0 | output | 32 | First word of the matched entry |
| pte1 | output | 32 | Second word of the matched entry, as read |
| pte_addr | output | 32 | Address of the matched entry |
| real_addr | output | 32 | Translated real address |

## Verification
The assertions take for granted three things about the inputs. rd_ack is raised only while rd_req is high, once per request. tbl_base is aligned to 64 bytes, so the low bits of a byte address identify the referenced or changed byte. tbl_base and tbl_mask do not change during a walk. The bench memory model answers only a pending request, with a random latency of zero to two cycles. It drops its acknowledge for at least one cycle after each answer. It holds the base at a 64-byte boundary and keeps the base and the mask fixed for the whole run.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
  localparam int unsigned XW        = 32;
  localparam int unsigned VSID_W    = 24;
  localparam int unsigned PIDX_W    = 16;
  localparam int unsigned API_W     = 6;
  localparam int unsigned PG_BITS   = 12;
  localparam int unsigned ENT_BYTES = 8;
  localparam int unsigned VLD_BIT   = 31;
  localparam int unsigned SEC_BIT   = 6;
  localparam int unsigned REF_BIT   = 8;
  localparam int unsigned CHG_BIT   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_SETR,
    ST_SETC,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/hptw_keygen.sv
module hptw_keygen
  import hptw_pkg::*;
#(
  parameter int unsigned GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              pass,
  input  logic [XW-1:0]     mask,
  output logic [XW-1:0]     tag,
  output logic [XW-1:0]     goff
);
  logic [XW-1:0] hash;
  logic [XW-1:0] hsel;

  always_comb begin
    hash = XW'(vsid) ^ XW'(pidx);
    hsel = pass ? ~hash : hash;
    goff = (hsel << GRP_SHIFT) & mask;
    tag  = XW'({1'b0, vsid, 1'b0, pidx[PIDX_W-1 -: API_W]});
  end
endmodule

// File: rtl/hptw_slot_cmp.sv
module hptw_slot_cmp
  import hptw_pkg::*;
(
  input  logic [XW-1:0] word0,
  input  logic [XW-1:0] tag,
  input  logic          pass,
  output logic          match
);
  localparam logic [XW-1:0] FLAG_BITS = (XW'(1) << VLD_BIT) | (XW'(1) << SEC_BIT);

  always_comb begin
    match = word0[VLD_BIT] && (word0[SEC_BIT] == pass) &&
            ((word0 & ~FLAG_BITS) == tag);
  end
endmodule

// File: rtl/hptw_top.sv
module hptw_top
  import hptw_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_sr,
  input  logic [31:0]   req_ea,
  input  logic          req_store,
  input  logic [31:0]   tbl_base,
  input  logic [31:0]   tbl_mask,
  output logic          rd_req,
  output logic [31:0]   rd_addr,
  input  logic          rd_ack,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [31:0]   wr_addr,
  output logic [7:0]    wr_byte,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic          no_write,
  output logic [31:0]   pte0,
  output logic [31:0]   pte1,
  output logic [31:0]   pte_addr,
  output logic [31:0]   real_addr
);
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned GRP_SHIFT = $clog2(SLOTS * ENT_BYTES);
  localparam int unsigned ENT_SH    = $clog2(ENT_BYTES);
  localparam int unsigned EA_KEEP   = PG_BITS + PIDX_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  walk_st_e            st_q, st_d;
  logic [VSID_W-1:0]   vsid_q;
  logic [EA_KEEP-1:0]  ea_q;
  logic                store_q;
  logic                pass_q, pass_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [XW-1:0]       w0_q, w1_q, paddr_q;
  logic                hit_q, nw_q;

  logic                take_req, take_w0, fin_hit, fin_miss;
  logic                match, need_c_rd, need_c_q;
  logic [XW-1:0]       tag, goff, ent_addr;
  logic                hi_bits_unused;

  assign hi_bits_unused = ^{req_sr[31:VSID_W], req_ea[31:EA_KEEP]};

  hptw_keygen #(.GRP_SHIFT(GRP_SHIFT)) u_keygen (
    .vsid (vsid_q),
    .pidx (ea_q[EA_KEEP-1:PG_BITS]),
    .pass (pass_q),
    .mask (tbl_mask),
    .tag  (tag),
    .goff (goff)
  );

  hptw_slot_cmp u_cmp (
    .word0 (rd_data),
    .tag   (tag),
    .pass  (pass_q),
    .match (match)
  );

  assign ent_addr  = tbl_base + goff + (XW'(slot_q) << ENT_SH);
  assign need_c_rd = !rd_data[CHG_BIT] && store_q;
  assign need_c_q  = !w1_q[CHG_BIT] && store_q;
  assign take_req  = (st_q == ST_IDLE) && req_valid;
  assign take_w0   = (st_q == ST_RD0) && rd_ack;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    pass_d   = pass_q;
    slot_d   = slot_q;
    fin_hit  = 1'b0;
    fin_miss = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_RD0;
          pass_d = 1'b0;
          slot_d = '0;
        end
      end
      ST_RD0: begin
        if (rd_ack) begin
          if (match) begin
            st_d = ST_RD1;
          end else if (slot_q == LAST_SLOT) begin
            if (pass_q) begin
              st_d     = ST_DONE;
              fin_miss = 1'b1;
            end else begin
              pass_d = 1'b1;
              slot_d = '0;
            end
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      ST_RD1: begin
        if (rd_ack) begin
          fin_hit = 1'b1;
          if (!rd_data[REF_BIT]) st_d = ST_SETR;
          else if (need_c_rd)    st_d = ST_SETC;
          else                   st_d = ST_DONE;
        end
      end
      ST_SETR: st_d = need_c_q ? ST_SETC : ST_DONE;
      ST_SETC: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      slot_q <= '0;
      hit_q  <= 1'b0;
      nw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      slot_q <= slot_d;
      if (take_req) begin
        hit_q <= 1'b0;
        nw_q  <= 1'b0;
      end else if (fin_hit) begin
        hit_q <= 1'b1;
        nw_q  <= !rd_data[CHG_BIT] && !store_q;
      end else if (fin_miss) begin
        hit_q <= 1'b0;
        nw_q  <= 1'b0;
      end
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (take_req) begin
      vsid_q  <= req_sr[VSID_W-1:0];
      ea_q    <= req_ea[EA_KEEP-1:0];
      store_q <= req_store;
    end
    if (take_w0) w0_q <= rd_data;
    if (fin_hit) begin
      w1_q    <= rd_data;
      paddr_q <= ent_addr;
    end
  end

  always_comb begin
    rd_req    = (st_q == ST_RD0) || (st_q == ST_RD1);
    rd_addr   = (st_q == ST_RD1) ? ent_addr + XW'(4) : ent_addr;
    wr_en     = (st_q == ST_SETR) || (st_q == ST_SETC);
    wr_addr   = (st_q == ST_SETR) ? ent_addr + XW'(6) : ent_addr + XW'(7);
    wr_byte   = (st_q == ST_SETR) ? (w1_q[15:8] | 8'h01) : (w1_q[7:0] | 8'h80);
    busy      = (st_q != ST_IDLE);
    done      = (st_q == ST_DONE);
    hit       = hit_q;
    no_write  = nw_q;
    pte0      = w0_q;
    pte1      = w1_q;
    pte_addr  = paddr_q;
    real_addr = {w1_q[XW-1:PG_BITS], ea_q[PG_BITS-1:0]};
  end
endmodule

// File: rtl/hptw_chk.sv
module hptw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_ack,
  input logic        wr_en,
  input logic [31:0] wr_addr,
  input logic [7:0]  wr_byte,
  input logic        busy,
  input logic        done,
  input logic        hit,
  input logic        no_write
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_en));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_en));

  // R7
  ref_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[0]) |-> (wr_byte[0] && wr_addr[2:1] == 2'b11));

  // R8
  chg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0]) |-> (wr_byte[7] && wr_addr[2:1] == 2'b11));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  nw_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_write) |-> hit);
endmodule

bind hptw_top hptw_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_ack   (rd_ack),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_byte  (wr_byte),
  .busy     (busy),
  .done     (done),
  .hit      (hit),
  .no_write (no_write)
);

// File: tb/hptw_top_tb.sv
module hptw_top_tb;
  localparam logic [31:0] BASE  = 32'h0010_0000;
  localparam logic [31:0] MASK  = 32'h0000_0FC0;
  localparam int          MEMW  = 1024;
  localparam int          NSLOT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_sr = '0;
  logic [31:0] req_ea = '0;
  logic        req_store = 1'b0;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_req, wr_en, busy, done, hit, no_write;
  logic [31:0] rd_addr, wr_addr, pte0, pte1, pte_addr, real_addr;
  logic [7:0]  wr_byte;

  logic [31:0] mem [0:MEMW-1];
  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int lat = 0;

  logic [31:0] g_rd [0:63];
  int          g_nrd;
  logic [31:0] g_wa [0:7];
  logic [7:0]  g_wb [0:7];
  int          g_nwr;
  logic [31:0] e_rd [0:63];
  int          e_nrd;
  logic [31:0] e_wa [0:7];
  logic [7:0]  e_wb [0:7];
  int          e_nwr;
  logic        e_hit, e_nw, e_prim;
  logic [31:0] e_w0, e_w1, e_addr;

  always #5 clk = ~clk;

  hptw_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sr(req_sr),
    .req_ea(req_ea), .req_store(req_store), .tbl_base(BASE), .tbl_mask(MASK),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .busy(busy),
    .done(done), .hit(hit), .no_write(no_write), .pte0(pte0), .pte1(pte1),
    .pte_addr(pte_addr), .real_addr(real_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  function automatic int widx(input logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 2;
    return int'(d[9:0]);
  endfunction

  function automatic logic [31:0] f_goff(input logic [31:0] sr, input logic [31:0] ea,
                                         input logic sec);
    logic [31:0] h;
    h = {8'h0, sr[23:0]} ^ {16'h0, ea[27:12]};
    if (sec) h = ~h;
    return (h << 6) & MASK;
  endfunction

  function automatic logic [31:0] f_tag(input logic [31:0] sr, input logic [31:0] ea);
    return {1'b0, sr[23:0], 1'b0, ea[27:22]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill_groups(input logic [31:0] sr, input logic [31:0] ea);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NSLOT; s++) begin
        logic [31:0] a;
        a = BASE + f_goff(sr, ea, p[0]) + 32'(s * 8);
        mem[widx(a)]     = $urandom;
        mem[widx(a + 4)] = $urandom;
      end
  endtask

  task automatic plant(input logic [31:0] sr, input logic [31:0] ea, input logic sec,
                       input int slot, input logic vld, input logic hflag,
                       input logic [31:0] w1);
    logic [31:0] a;
    a = BASE + f_goff(sr, ea, sec) + 32'(slot * 8);
    mem[widx(a)]     = f_tag(sr, ea) | ({31'h0, vld} << 31) | ({31'h0, hflag} << 6);
    mem[widx(a + 4)] = w1;
  endtask

  // reference walk from the requirements, on the current memory image
  task automatic ref_walk(input logic [31:0] sr, input logic [31:0] ea, input logic st);
    logic        found;
    logic [31:0] a, w, tg;
    found = 1'b0; e_nrd = 0; e_nwr = 0; e_nw = 1'b0; e_prim = 1'b0;
    e_w0 = '0; e_w1 = '0; e_addr = '0;
    tg = f_tag(sr, ea);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NSLOT; s++)
        if (!found) begin
          a = BASE + f_goff(sr, ea, p[0]) + 32'(s * 8);
          e_rd[e_nrd] = a; e_nrd++;
          w = mem[widx(a)];
          if (w[31] && (w[6] == p[0]) && ((w & 32'h7FFF_FFBF) == tg)) begin
            found = 1'b1;
            e_rd[e_nrd] = a + 4; e_nrd++;
            e_w0 = w; e_w1 = mem[widx(a + 4)]; e_addr = a; e_prim = (p == 0);
          end
        end
    e_hit = found;
    if (found) begin
      if (!e_w1[8]) begin
        e_wa[e_nwr] = e_addr + 6; e_wb[e_nwr] = e_w1[15:8] | 8'h01; e_nwr++;
      end
      if (!e_w1[7] && st) begin
        e_wa[e_nwr] = e_addr + 7; e_wb[e_nwr] = e_w1[7:0] | 8'h80; e_nwr++;
      end
      e_nw = !e_w1[7] && !st;
    end
  endtask

  task automatic run_walk(input logic [31:0] sr, input logic [31:0] ea, input logic st,
                          input logic poke);
    bit finished;
    ref_walk(sr, ea, st);
    g_nrd = 0; g_nwr = 0; lat = 0; finished = 0;
    @(negedge clk);
    req_valid = 1'b1; req_sr = sr; req_ea = ea; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      req_valid = 1'b0;
      if (wr_en) begin
        int wi;
        wi = widx(wr_addr);
        case (wr_addr[1:0])
          2'd0: mem[wi][31:24] = wr_byte;
          2'd1: mem[wi][23:16] = wr_byte;
          2'd2: mem[wi][15:8]  = wr_byte;
          default: mem[wi][7:0] = wr_byte;
        endcase
        if (g_nwr < 8) begin g_wa[g_nwr] = wr_addr; g_wb[g_nwr] = wr_byte; end
        g_nwr++;
      end
      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req) begin
        if (lat == 0) begin
          rd_ack = 1'b1;
          rd_data = mem[widx(rd_addr)];
          if (g_nrd < 64) g_rd[g_nrd] = rd_addr;
          g_nrd++;
          lat = int'($urandom % 3);
        end else begin
          lat--;
        end
      end
      if (done) begin finished = 1; break; end
      if (poke && cyc == 3 && busy) begin
        req_valid = 1'b1; req_sr = ~sr; req_ea = ~ea; req_store = ~st;
      end
    end
    rd_ack = 1'b0;
    if (!finished) chk("R6 walk completes", 32'd0, 32'd1);
    // R3 / R6: outcome
    chk(e_hit ? "R3 hit" : "R6 hit", {31'h0, hit}, {31'h0, e_hit});
    // R9
    chk("R9 no_write", {31'h0, no_write}, {31'h0, e_nw});
    // R4 read sequence
    chk("R4 read count", 32'(g_nrd), 32'(e_nrd));
    for (int i = 0; i < e_nrd && i < g_nrd && i < 64; i++)
      chk(i == 0 ? "R2 first read" : "R4 read order", g_rd[i], e_rd[i]);
    // R5: secondary group begins after eight primary misses
    if (!e_prim && g_nrd > 8) chk("R5 secondary start", g_rd[8], e_rd[8]);
    // R7 / R8 byte updates
    chk(e_hit ? "R7 write count" : "R6 write count", 32'(g_nwr), 32'(e_nwr));
    for (int i = 0; i < e_nwr && i < g_nwr && i < 8; i++) begin
      chk(e_wa[i][0] ? "R8 addr" : "R7 addr", g_wa[i], e_wa[i]);
      chk(e_wa[i][0] ? "R8 byte" : "R7 byte", {24'h0, g_wb[i]}, {24'h0, e_wb[i]});
    end
    if (e_hit) begin
      // R10
      chk("R10 pte0", pte0, e_w0);
      chk("R10 pte1", pte1, e_w1);
      chk("R10 pte_addr", pte_addr, e_addr);
      chk("R10 real_addr", real_addr, {e_w1[31:12], ea[11:0]});
    end
    if (poke) begin
      // R11: result belongs to the original request
      chk("R11 hit kept", {31'h0, hit}, {31'h0, e_hit});
      chk("R11 reads kept", 32'(g_nrd), 32'(e_nrd));
    end
    @(negedge clk);
    chk("R1 idle after walk", {31'h0, busy}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy in reset", {31'h0, busy}, 32'd0);
    chk("R1 done in reset", {31'h0, done}, 32'd0);
    chk("R1 rd_req in reset", {31'h0, rd_req}, 32'd0);
    chk("R1 wr_en in reset", {31'h0, wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {30'h0, busy, rd_req}, 32'd0);

    // miss in both groups, with a request poked while busy (R6, R11)
    fill_groups(32'h00AB_CDEF, 32'h1234_5678);
    run_walk(32'h00AB_CDEF, 32'h1234_5678, 1'b0, 1'b1);

    // primary slot 0, R and C clear, store (R7, R8)
    fill_groups(32'hFF12_3456, 32'h0FED_C123);
    plant(32'hFF12_3456, 32'h0FED_C123, 1'b0, 0, 1'b1, 1'b0, 32'hABCD_E002);
    run_walk(32'hFF12_3456, 32'h0FED_C123, 1'b1, 1'b0);

    // load with C clear, R set: withheld write, no bytes (R9)
    fill_groups(32'h0000_0001, 32'h7000_1FFF);
    plant(32'h0000_0001, 32'h7000_1FFF, 1'b0, 4, 1'b1, 1'b0, 32'h1111_1101);
    run_walk(32'h0000_0001, 32'h7000_1FFF, 1'b0, 1'b0);

    // secondary slot 7 behind decoys: wrong pass flag and invalid (R3, R5)
    fill_groups(32'h0055_AA55, 32'hAAAA_5555);
    plant(32'h0055_AA55, 32'hAAAA_5555, 1'b0, 2, 1'b1, 1'b1, 32'h2222_0000);
    plant(32'h0055_AA55, 32'hAAAA_5555, 1'b1, 1, 1'b0, 1'b1, 32'h3333_0000);
    plant(32'h0055_AA55, 32'hAAAA_5555, 1'b1, 7, 1'b1, 1'b1, 32'h4444_5100);
    run_walk(32'h0055_AA55, 32'hAAAA_5555, 1'b1, 1'b0);

    // R and C already set: no byte writes (R7, R8)
    fill_groups(32'h0012_0000, 32'h0000_0ABC);
    plant(32'h0012_0000, 32'h0000_0ABC, 1'b0, 7, 1'b1, 1'b0, 32'h8765_4183);
    run_walk(32'h0012_0000, 32'h0000_0ABC, 1'b1, 1'b0);

    // constrained random walks
    for (int n = 0; n < 80; n++) begin
      logic [31:0] sr, ea, w1;
      int          kind, slot;
      sr = $urandom; ea = $urandom; w1 = $urandom;
      kind = int'($urandom % 3); slot = int'($urandom % NSLOT);
      fill_groups(sr, ea);
      if (kind != 0) begin
        for (int d = 0; d < slot; d++)
          if ($urandom % 2 == 1)
            plant(sr, ea, kind == 2, d, $urandom % 2 == 1, kind != 2, $urandom);
        plant(sr, ea, kind == 2, slot, 1'b1, kind == 2, w1);
      end
      run_walk(sr, ea, $urandom % 2 == 1, kind == 0 && (n % 4 == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule